// File: doc/BRIEF.md
# ADC Programming-Interface Register Stub

This block presents the register-level programming model of a multi-channel successive-approximation ADC, with no analog circuitry behind it. Software reaches a 256-byte window of 32-bit registers through a plain strobe bus with address, write enable, write data, read enable and read data. The window holds two control words, a status word, sample-time and threshold words, regular and injected sequence words, four injected offset/data pairs and a regular result register.

A conversion needs no time in this stub. When software reads the result register while the converter is powered on and a software start is pending, the read produces a synthetic sample and clears the pending start. The sample comes from a running value that advances by 7 on each conversion and is cut to the resolution chosen in control word 1. If the alignment bit in control word 2 is set, the returned sample is also shifted into left-aligned form. The block lets firmware drivers and bus fabrics be brought up before a real converter exists.

Top module: `adc_regstub`

## Requirements
- R1: After reset every register reads 0x00000000, except the high threshold register (offset 0x24), which reads 0x00000FFF.
- R2: A result read (offset 0x4C) with control word 2 bit 0 (power on) and bit 30 (software start) both set stores (previous + 7) masked by the resolution field, bits 25:24 of control word 1 (offset 0x04): 0 keeps 12 bits, 1 keeps 10, 2 keeps 8 and 3 keeps 6. That stored value is returned.
- R3: When control word 2 bit 11 is set, a triggered result read returns (stored << 1) & 0xFFF0 instead of the stored value.
- R4: A triggered result read clears control word 2 bit 30. A following result read returns 0 until software sets bit 30 again, and the next triggered sample continues from the last stored value.
- R5: A result read without both bit 0 and bit 30 set returns 0 and leaves the running value unchanged.
- R6: Control word 2 (offset 0x08) reads back bits 27:0 of the value written, with bits 31:28 read as zero.
- R7: A write to status (offset 0x00) ANDs the status with the low 6 bits of the written data. Because nothing in the stub sets a status flag, status always reads 0.
- R8: Injected offset registers (0x14, 0x18, 0x1C, 0x20) store only the low 12 bits of a write. A read of injected data register n (0x3C + 4n) returns the stored data minus offset n, modulo 2^32.
- R9: Reads at unmapped offsets (above 0x4C, or with address bits 1:0 nonzero) return 0, and writes there have no effect. Writes to the result register have no effect either.
- R10: Read data appears on rdata_o in the cycle after the read strobe and holds while re_i is low.
- R11: Control word 1, both sample-time words (0x0C, 0x10), both thresholds (0x24, 0x28), the three regular sequence words (0x2C–0x34) and the injected sequence word (0x38) read back all 32 bits written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Byte address within the window |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |

## Verification
The bench triggers more than 585 conversions at 12-bit resolution so that the running value wraps past 0xFFF. A design that masked before adding, or that failed to store the masked value back, would drift away from the model there. It also runs each of the other resolutions with alignment on and off, which exposes a wrong mask width or a wrong shift-and-mask. Untriggered result reads follow consumed starts and starts with the power bit clear: a design that failed to clear the start bit, or that advanced the running value on an idle read, returns a nonzero or skipped sample. The bench also reads control word 2 after writing all ones, sets an injected offset larger than its data so that the subtraction must wrap, and writes to the result register and to misaligned or unmapped addresses, then reads the neighbouring registers to confirm that nothing changed.

// File: rtl/adc_regstub_pkg.sv
package adc_regstub_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned NUM_INJ   = 4;
  localparam int unsigned RAW_W     = 12;
  localparam int unsigned STEP      = 7;
  localparam int unsigned STAT_W    = 6;
  localparam int unsigned IDX_W     = ADDR_W - 2;
  localparam logic [DATA_W-1:0] ALIGN_MASK = 32'h0000_FFF0;
  localparam logic [DATA_W-1:0] HTR_RST    = 32'h0000_0FFF;

  // word indices (byte offset / 4)
  localparam logic [IDX_W-1:0] W_STAT  = 6'd0;
  localparam logic [IDX_W-1:0] W_CTL1  = 6'd1;
  localparam logic [IDX_W-1:0] W_CTL2  = 6'd2;
  localparam logic [IDX_W-1:0] W_SMP1  = 6'd3;
  localparam logic [IDX_W-1:0] W_SMP2  = 6'd4;
  localparam logic [IDX_W-1:0] W_IOFF0 = 6'd5;
  localparam logic [IDX_W-1:0] W_HTHR  = 6'd9;
  localparam logic [IDX_W-1:0] W_LTHR  = 6'd10;
  localparam logic [IDX_W-1:0] W_RSQ1  = 6'd11;
  localparam logic [IDX_W-1:0] W_RSQ2  = 6'd12;
  localparam logic [IDX_W-1:0] W_RSQ3  = 6'd13;
  localparam logic [IDX_W-1:0] W_ISEQ  = 6'd14;
  localparam logic [IDX_W-1:0] W_IDAT0 = 6'd15;
  localparam logic [IDX_W-1:0] W_RES   = 6'd19;

  localparam int unsigned CTL2_ON    = 0;
  localparam int unsigned CTL2_ALIGN = 11;
  localparam int unsigned CTL2_START = 30;
  localparam int unsigned CTL2_RDW   = 28;
  localparam int unsigned RES_LSB    = 24;

  typedef enum logic [1:0] {
    RES_12 = 2'd0,
    RES_10 = 2'd1,
    RES_8  = 2'd2,
    RES_6  = 2'd3
  } res_e;
endpackage

// File: rtl/adc_sample_gen.sv
module adc_sample_gen
  import adc_regstub_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  res_e              res_i,
  input  logic              align_i,
  output logic [DATA_W-1:0] sample_o
);
  logic [RAW_W-1:0] val_q;
  logic [RAW_W-1:0] mask;
  logic [RAW_W-1:0] next_val;
  logic [DATA_W-1:0] shifted;

  assign mask     = {RAW_W{1'b1}} >> (2 * int'(res_i));
  assign next_val = (val_q + RAW_W'(STEP)) & mask;
  assign shifted  = DATA_W'({next_val, 1'b0}) & ALIGN_MASK;
  assign sample_o = align_i ? shifted : DATA_W'(next_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (fire_i) val_q <= next_val;
  end
endmodule

// File: rtl/adc_inj_bank.sv
module adc_inj_bank
  import adc_regstub_pkg::*;
#(
  parameter int unsigned N = NUM_INJ,
  localparam int unsigned SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      off_we_i,
  input  logic [N-1:0]      dat_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [DATA_W-1:0] off_rd_o,
  output logic [DATA_W-1:0] dat_rd_o
);
  logic [RAW_W-1:0]  off_q [N];
  logic [DATA_W-1:0] dat_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        off_q[g] <= '0;
        dat_q[g] <= '0;
      end else begin
        if (off_we_i[g]) off_q[g] <= wdata_i[RAW_W-1:0];
        if (dat_we_i[g]) dat_q[g] <= wdata_i;
      end
    end
  end

  assign off_rd_o = DATA_W'(off_q[sel_i]);
  assign dat_rd_o = dat_q[sel_i] - DATA_W'(off_q[sel_i]);
endmodule

// File: rtl/adc_regstub.sv
module adc_regstub
  import adc_regstub_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned SEL_W = (NUM_INJ > 1) ? $clog2(NUM_INJ) : 1;

  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic              in_ioff, in_idat;
  logic [SEL_W-1:0]  inj_sel;
  logic [NUM_INJ-1:0] off_we, dat_we;

  logic [STAT_W-1:0] stat_q;
  logic [DATA_W-1:0] ctl1_q, ctl2_q, smp1_q, smp2_q, hthr_q, lthr_q;
  logic [DATA_W-1:0] rsq1_q, rsq2_q, rsq3_q, iseq_q;
  logic [DATA_W-1:0] rd_val, rdata_q, sample, off_rd, dat_rd;
  logic              fire;

  assign idx     = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign in_ioff = aligned && idx >= W_IOFF0 && idx < W_IOFF0 + IDX_W'(NUM_INJ);
  assign in_idat = aligned && idx >= W_IDAT0 && idx < W_IDAT0 + IDX_W'(NUM_INJ);
  assign inj_sel = in_idat ? SEL_W'(idx - W_IDAT0) : SEL_W'(idx - W_IOFF0);

  for (genvar g = 0; g < NUM_INJ; g++) begin : g_we
    assign off_we[g] = we_i && in_ioff && (inj_sel == SEL_W'(g));
    assign dat_we[g] = we_i && in_idat && (inj_sel == SEL_W'(g));
  end

  assign fire = re_i && aligned && (idx == W_RES) &&
                ctl2_q[CTL2_ON] && ctl2_q[CTL2_START];

  adc_sample_gen i_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .res_i    (res_e'(ctl1_q[RES_LSB+1:RES_LSB])),
    .align_i  (ctl2_q[CTL2_ALIGN]),
    .sample_o (sample)
  );

  adc_inj_bank #(.N(NUM_INJ)) i_inj (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .off_we_i (off_we),
    .dat_we_i (dat_we),
    .wdata_i  (wdata_i),
    .sel_i    (inj_sel),
    .off_rd_o (off_rd),
    .dat_rd_o (dat_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      ctl1_q <= '0;
      ctl2_q <= '0;
      smp1_q <= '0;
      smp2_q <= '0;
      hthr_q <= HTR_RST;
      lthr_q <= '0;
      rsq1_q <= '0;
      rsq2_q <= '0;
      rsq3_q <= '0;
      iseq_q <= '0;
    end else begin
      if (we_i && aligned) begin
        unique case (idx)
          W_STAT:  stat_q <= stat_q & wdata_i[STAT_W-1:0];
          W_CTL1:  ctl1_q <= wdata_i;
          W_CTL2:  ctl2_q <= wdata_i;
          W_SMP1:  smp1_q <= wdata_i;
          W_SMP2:  smp2_q <= wdata_i;
          W_HTHR:  hthr_q <= wdata_i;
          W_LTHR:  lthr_q <= wdata_i;
          W_RSQ1:  rsq1_q <= wdata_i;
          W_RSQ2:  rsq2_q <= wdata_i;
          W_RSQ3:  rsq3_q <= wdata_i;
          W_ISEQ:  iseq_q <= wdata_i;
          default: ;
        endcase
      end
      // fire only at the result offset, so never races a control-2 write
      if (fire) ctl2_q[CTL2_START] <= 1'b0;
    end
  end

  always_comb begin
    rd_val = '0;
    if (aligned) begin
      if (in_ioff)      rd_val = off_rd;
      else if (in_idat) rd_val = dat_rd;
      else begin
        unique case (idx)
          W_STAT:  rd_val = DATA_W'(stat_q);
          W_CTL1:  rd_val = ctl1_q;
          W_CTL2:  rd_val = {{(DATA_W-CTL2_RDW){1'b0}}, ctl2_q[CTL2_RDW-1:0]};
          W_SMP1:  rd_val = smp1_q;
          W_SMP2:  rd_val = smp2_q;
          W_HTHR:  rd_val = hthr_q;
          W_LTHR:  rd_val = lthr_q;
          W_RSQ1:  rd_val = rsq1_q;
          W_RSQ2:  rd_val = rsq2_q;
          W_RSQ3:  rd_val = rsq3_q;
          W_ISEQ:  rd_val = iseq_q;
          W_RES:   rd_val = fire ? sample : '0;
          default: rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/adc_regstub_chk.sv
module adc_regstub_chk
  import adc_regstub_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              re_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] ctl2_i,
  input logic [DATA_W-1:0] ctl1_i
);
  logic hit_res, unmapped, trig;
  assign hit_res  = (addr_i == 8'h4C);
  assign unmapped = (addr_i[1:0] != 2'b00) || (addr_i > 8'h4C);
  assign trig     = ctl2_i[0] && ctl2_i[30];

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  p_ctl2_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == 8'h08) |=> (rdata_o[31:28] == 4'h0));

  p_idle_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && hit_res && !trig) |=> (rdata_o == '0));

  p_start_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && hit_res && trig) |=> !ctl2_i[30]);

  p_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && unmapped) |=> (rdata_o == '0));

  p_status_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == 8'h00) |=> (rdata_o == '0));

  p_six_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && hit_res && trig && ctl1_i[25:24] == 2'd3 && !ctl2_i[11])
      |=> (rdata_o < 32'd64));
endmodule

bind adc_regstub adc_regstub_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .re_i    (re_i),
  .rdata_o (rdata_o),
  .ctl2_i  (ctl2_q),
  .ctl1_i  (ctl1_q)
);

// File: tb/test_adc_regstub.sv
`timescale 1ns/1ps
module test_adc_regstub;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        re_i = 1'b0;
  logic [31:0] rdata_o;

  int n_run = 0;
  int n_fail = 0;
  logic pend = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          m_val = 0;

  always #2 clk_i = ~clk_i;

  adc_regstub i_adc_regstub (.*);

  always @(posedge clk_i) pend <= re_i;

  // monitor: compares each registered read result against the queue
  always @(negedge clk_i) begin
    if (pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (rdata_o !== e) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", t, rdata_o, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk_i);
    addr_i = a; re_i = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk_i);
    re_i = 1'b0;
  endtask

  function automatic logic [31:0] model(input int res, input bit align);
    int mask;
    mask = 32'hFFF >> (2 * res);
    m_val = (m_val + 7) & mask;
    return align ? ((m_val << 1) & 32'hFFF0) : m_val;
  endfunction

  task automatic conv(input int res, input bit align, input string t);
    wr(8'h04, res << 24);
    wr(8'h08, 32'h4000_0001 | (align ? 32'h800 : 0));
    rd(8'h4C, model(res, align), t);
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset values
    for (int a = 0; a <= 'h48; a += 4)
      rd(a[7:0], (a == 'h24) ? 32'h0000_0FFF : 32'h0, "R1 reset");
    rd(8'h4C, 32'h0, "R5 idle result after reset");

    // R11 plain read/write
    wr(8'h04, 32'hA5A5_5A5A); rd(8'h04, 32'hA5A5_5A5A, "R11 ctl1");
    wr(8'h0C, 32'h1234_5678); rd(8'h0C, 32'h1234_5678, "R11 smp1");
    wr(8'h10, 32'hFEDC_BA98); rd(8'h10, 32'hFEDC_BA98, "R11 smp2");
    wr(8'h24, 32'hDEAD_BEEF); rd(8'h24, 32'hDEAD_BEEF, "R11 hthr");
    wr(8'h28, 32'h0BAD_F00D); rd(8'h28, 32'h0BAD_F00D, "R11 lthr");
    wr(8'h2C, 32'h1111_2222); rd(8'h2C, 32'h1111_2222, "R11 rsq1");
    wr(8'h30, 32'h3333_4444); rd(8'h30, 32'h3333_4444, "R11 rsq2");
    wr(8'h34, 32'h5555_6666); rd(8'h34, 32'h5555_6666, "R11 rsq3");
    wr(8'h38, 32'h7777_8888); rd(8'h38, 32'h7777_8888, "R11 iseq");

    // R6 ctl2 mask; all-ones also triggers with align at 10-bit (ctl1 bits 25:24 = 01)
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h0FFF_FFFF, "R6 ctl2 upper bits");
    rd(8'h4C, model(1, 1'b1), "R3 aligned 10-bit");
    rd(8'h08, 32'h0FFF_FFFF, "R6 ctl2 after start clear");
    rd(8'h4C, 32'h0, "R4 start consumed");
    rd(8'h4C, 32'h0, "R4 start consumed again");

    // R2 12-bit through wrap
    for (int i = 0; i < 600; i++) conv(0, 1'b0, "R2 12-bit");
    for (int i = 0; i < 120; i++) conv(1, 1'b0, "R2 10-bit");
    for (int i = 0; i < 30; i++)  conv(2, 1'b0, "R2 8-bit");
    for (int i = 0; i < 12; i++)  conv(3, 1'b0, "R2 6-bit");
    for (int i = 0; i < 12; i++)  conv(3, 1'b1, "R3 aligned 6-bit");
    for (int i = 0; i < 40; i++)  conv(2, 1'b1, "R3 aligned 8-bit");
    for (int i = 0; i < 20; i++)  conv(0, 1'b1, "R3 aligned 12-bit");

    // R5 start without power, power without start: counter must not move
    wr(8'h08, 32'h4000_0000); rd(8'h4C, 32'h0, "R5 start without power");
    wr(8'h08, 32'h0000_0001); rd(8'h4C, 32'h0, "R5 power without start");
    conv(0, 1'b0, "R5 counter unchanged");

    // R7 status
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, 32'h0, "R7 status ones");
    wr(8'h00, 32'h0);         rd(8'h00, 32'h0, "R7 status zeros");

    // R8 injected
    wr(8'h14, 32'h0001_2345); rd(8'h14, 32'h0000_0345, "R8 offset 12-bit");
    wr(8'h3C, 32'h0000_1000); rd(8'h3C, 32'h0000_0CBB, "R8 data minus offset");
    wr(8'h18, 32'h0000_0010); wr(8'h40, 32'h0000_0005);
    rd(8'h40, 32'hFFFF_FFF5, "R8 wrapped difference");
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h48, 32'h0);
    rd(8'h20, 32'h0000_0FFF, "R8 last offset");
    rd(8'h48, 32'hFFFF_F001, "R8 last data");
    rd(8'h44, 32'h0, "R8 untouched entry");

    // R9 unmapped and ignored writes
    rd(8'h50, 32'h0, "R9 above window");
    rd(8'hFC, 32'h0, "R9 top of window");
    rd(8'h05, 32'h0, "R9 misaligned read");
    wr(8'h25, 32'h0000_0001); rd(8'h24, 32'hDEAD_BEEF, "R9 misaligned write");
    wr(8'h50, 32'hFFFF_FFFF); rd(8'h50, 32'h0, "R9 unmapped write");
    wr(8'h4C, 32'h0000_0800);
    conv(0, 1'b0, "R9 result write ignored");

    // R10 hold
    rd(8'h28, 32'h0BAD_F00D, "R10 read");
    repeat (4) @(negedge clk_i);
    n_run++;
    if (rdata_o !== 32'h0BAD_F00D) begin
      n_fail++;
      $display("FAIL R10 hold: got %h expected %h", rdata_o, 32'h0BAD_F00D);
    end

    repeat (3) @(negedge clk_i);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule